// File: doc/BRIEF.md
# Dual-Class Vectored Interrupt Controller

The block collects up to 32 interrupt sources. It latches each source into a status register and sends each pending, enabled source to one of two request outputs: a normal request or a critical request. Software reaches every register through a simple single-cycle register port. The port has a write strobe, a 4-bit offset and write data. Read data is combinational on the offset.

Each source has its own trigger type:

- **Sticky (edge) source:** a high sample sets its status bit, and the bit stays set until software clears it.
- **Level source:** the status bit tracks the input on every clock.

A per-source class-select register decides which output a source drives. When the `USE_VECTORS` parameter is set, the block also forms a handler address for the critical class. The address is a programmable base plus 512 bytes for each priority slot. The priority scan runs from either end of the pending word, and a configuration bit chooses the end.

The design has no sequencing state machine. All behaviour comes from the register state (status, level latch, configuration) and combinational decode. Writes land on the next rising clock edge. Outputs, masked status and the vector follow the registered state with no further delay.

Top module: `dual_class_irq_ctrl`

## Requirements
- R1: Register offsets are: 0 status (write 1 to clear), 1 status set, 2 enable, 3 class select (1 = critical), 4 polarity, 5 trigger type, 6 masked status, 7 vector, 8 vector configuration. Offsets 2 to 5 read back the last value written. Reads of offsets 0 and 1 both return status. A write takes effect at the next rising clock edge.
- R2: Input line n is held in status bit 31 − n, so input 0 is the most significant bit.
- R3: A source whose trigger bit is 1 is a sticky source. Each clock on which its input is 1 sets its status bit, and an input of 0 never clears the bit.
- R4: A source whose trigger bit is 0 is a level source. Its status bit and its level-latch bit take the input value on every clock. This overrides any register write in the same cycle.
- R5: A write to offset 0 clears the status bits written as 1, then ORs the level-latch bits back in, so a level source that is still high stays pending. A write to offset 1 ORs the written value into status.
- R6: `irq_norm` is high exactly when status & enable & ~select is nonzero. `irq_crit` is high exactly when status & enable & select is nonzero.
- R7: A read of offset 6 returns status & enable. Writes to offsets 6 and 7 change no register.
- R8: A write to offset 8 stores the written value with bit 1 forced to 0.
- R9: While a critical source is pending, the vector is (configuration with bits 1:0 cleared) + 512·k. If configuration bit 0 is 0, k is the index of the lowest pending critical bit. If bit 0 is 1, k is 31 minus the index of the highest pending critical bit.
- R10: The vector reads 0 when no critical source is pending. With `USE_VECTORS` = 0, offsets 7 and 8 read 0.
- R11: After reset, every register (status, level latch, enable, select, polarity, trigger, vector configuration) is 0, both outputs are low, and every offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NSRC | Interrupt source lines, line n maps to status bit NSRC-1-n |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Combinational read data for `reg_addr` |
| irq_norm | output | 1 | Normal-class interrupt request |
| irq_crit | output | 1 | Critical-class interrupt request |

## Verification
The hardest case to reach from the ports is the priority scan with more than one critical bit pending. A single pending bit cannot show whether the lowest or the highest index wins. The bench therefore switches every source to sticky mode, injects two status bits seven positions apart through the status-set offset, and sweeps all 32 positions in both scan directions. The expected vector is computed arithmetically each time. A second case that needs care is a clear write on a level source whose input is still high: the bench holds the line, issues the clear, and checks that the bit is still set.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [3:0] {
        REG_STAT     = 4'd0,
        REG_STAT_SET = 4'd1,
        REG_ENABLE   = 4'd2,
        REG_CLASS    = 4'd3,
        REG_POLAR    = 4'd4,
        REG_TRIG     = 4'd5,
        REG_MASKED   = 4'd6,
        REG_VECTOR   = 4'd7,
        REG_VCFG     = 4'd8
    } reg_off_e;

endpackage

// File: rtl/intc_status.sv
module intc_status #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_bits,
    input  logic [NSRC-1:0] trig,
    input  logic            clr_we,
    input  logic            set_we,
    input  logic [NSRC-1:0] wmask,
    output logic [NSRC-1:0] status,
    output logic [NSRC-1:0] lvl
);

    logic [NSRC-1:0] clr_mask;
    logic [NSRC-1:0] base;
    logic [NSRC-1:0] status_nxt;
    logic [NSRC-1:0] lvl_nxt;
    logic [NSRC-1:0] keep_mask;

    assign clr_mask = clr_we ? wmask : '0;

    always_comb begin
        base = status;
        if (clr_we) begin
            base = (status & ~clr_mask) | lvl;
        end else if (set_we) begin
            base = status | wmask;
        end
        status_nxt = ((base | src_bits) & trig) | (src_bits & ~trig);
        lvl_nxt    = src_bits & ~trig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            lvl    <= '0;
        end else begin
            status <= status_nxt;
            lvl    <= lvl_nxt;
        end
    end

    assign keep_mask = trig & status & ~clr_mask;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|keep_mask) |=> ((status & $past(keep_mask)) == $past(keep_mask))); // R3

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~trig)) |=> ((status & ~$past(trig)) == ($past(src_bits) & ~$past(trig)))); // R4

    AST_CLEAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((status & $past(trig & wmask & ~src_bits)) == '0)); // R5

    AST_SET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((status & $past(trig & wmask)) == $past(trig & wmask))); // R5

endmodule

// File: rtl/intc_vector.sv
module intc_vector #(
    parameter int NSRC      = 32,
    parameter int DW        = 32,
    parameter int STRIDE_LG = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] crit_pend,
    input  logic [DW-1:0]   vcfg,
    output logic [DW-1:0]   vector
);

    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [IW-1:0] slot;
    logic          found;

    always_comb begin
        slot  = '0;
        found = 1'b0;
        if (!vcfg[0]) begin
            for (int i = 0; i < NSRC; i++) begin
                if (!found && crit_pend[i]) begin
                    slot  = IW'(i);
                    found = 1'b1;
                end
            end
        end else begin
            for (int i = NSRC - 1; i >= 0; i--) begin
                if (!found && crit_pend[i]) begin
                    slot  = IW'(NSRC - 1 - i);
                    found = 1'b1;
                end
            end
        end
        vector = found ? ((vcfg & ~DW'(3)) + (DW'(slot) << STRIDE_LG)) : '0;
    end

    AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_pend == '0) |-> (vector == '0)); // R10

    AST_VEC_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|crit_pend) |-> (vector[1:0] == 2'b00)); // R9

endmodule

// File: rtl/dual_class_irq_ctrl.sv
module dual_class_irq_ctrl
    import intc_pkg::*;
#(
    parameter int NSRC        = 32,
    parameter int DW          = 32,
    parameter bit USE_VECTORS = 1'b1,
    parameter int STRIDE_LG   = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic            reg_wr,
    input  logic [3:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            irq_norm,
    output logic            irq_crit
);

    logic [NSRC-1:0] src_bits;
    logic [NSRC-1:0] status;
    logic [NSRC-1:0] lvl;
    logic [NSRC-1:0] enable_q;
    logic [NSRC-1:0] class_q;
    logic [NSRC-1:0] polar_q;
    logic [NSRC-1:0] trig_q;
    logic [NSRC-1:0] wmask;
    logic [NSRC-1:0] norm_pend;
    logic [NSRC-1:0] crit_pend;
    logic [DW-1:0]   vcfg_q;
    logic [DW-1:0]   vector;
    reg_off_e        off;
    logic            wr_clr;
    logic            wr_set;

    for (genvar n = 0; n < NSRC; n++) begin : g_swap
        assign src_bits[NSRC-1-n] = irq_in[n];
    end

    assign off    = reg_off_e'(reg_addr);
    assign wmask  = reg_wdata[NSRC-1:0];
    assign wr_clr = reg_wr && (off == REG_STAT);
    assign wr_set = reg_wr && (off == REG_STAT_SET);

    intc_status #(.NSRC(NSRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_bits (src_bits),
        .trig     (trig_q),
        .clr_we   (wr_clr),
        .set_we   (wr_set),
        .wmask    (wmask),
        .status   (status),
        .lvl      (lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            class_q  <= '0;
            polar_q  <= '0;
            trig_q   <= '0;
        end else if (reg_wr) begin
            case (off)
                REG_ENABLE: enable_q <= wmask;
                REG_CLASS:  class_q  <= wmask;
                REG_POLAR:  polar_q  <= wmask;
                REG_TRIG:   trig_q   <= wmask;
                default:    ;
            endcase
        end
    end

    assign norm_pend = status & enable_q & ~class_q;
    assign crit_pend = status & enable_q & class_q;
    assign irq_norm  = |norm_pend;
    assign irq_crit  = |crit_pend;

    if (USE_VECTORS) begin : g_vec
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vcfg_q <= '0;
            end else if (reg_wr && (off == REG_VCFG)) begin
                vcfg_q <= reg_wdata & ~DW'(2);
            end
        end

        intc_vector #(.NSRC(NSRC), .DW(DW), .STRIDE_LG(STRIDE_LG)) u_vector (
            .clk       (clk),
            .rst_n     (rst_n),
            .crit_pend (crit_pend),
            .vcfg      (vcfg_q),
            .vector    (vector)
        );

        AST_CFG_STORE: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && (off == REG_VCFG)) |=> (vcfg_q == ($past(reg_wdata) & ~DW'(2)))); // R8
    end else begin : g_novec
        assign vcfg_q = '0;
        assign vector = '0;
    end

    always_comb begin
        case (off)
            REG_STAT, REG_STAT_SET: reg_rdata = DW'(status);
            REG_ENABLE:             reg_rdata = DW'(enable_q);
            REG_CLASS:              reg_rdata = DW'(class_q);
            REG_POLAR:              reg_rdata = DW'(polar_q);
            REG_TRIG:               reg_rdata = DW'(trig_q);
            REG_MASKED:             reg_rdata = DW'(status & enable_q);
            REG_VECTOR:             reg_rdata = vector;
            REG_VCFG:               reg_rdata = vcfg_q;
            default:                reg_rdata = '0;
        endcase
    end

    AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (off == REG_ENABLE)) |=> (enable_q == $past(wmask))); // R1

    AST_RO_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && ((off == REG_MASKED) || (off == REG_VECTOR)))
            |=> ($stable(enable_q) && $stable(class_q) && $stable(trig_q) && $stable(vcfg_q))); // R7

endmodule

// File: tb/dual_class_irq_ctrl_bench.sv
module dual_class_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_in;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_norm;
    logic        irq_crit;
    logic [31:0] rdata_nv;
    logic        norm_nv;
    logic        crit_nv;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    dual_class_irq_ctrl u_dual_class_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_norm(irq_norm), .irq_crit(irq_crit)
    );

    dual_class_irq_ctrl #(.USE_VECTORS(1'b0)) u_dual_class_irq_ctrl_novec (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_nv),
        .irq_norm(norm_nv), .irq_crit(crit_nv)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    function automatic logic [31:0] pat(input int k);
        case (k)
            0:       return 32'h0000_0000;
            1:       return 32'h8000_0001;
            2:       return 32'h00FF_FF00;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq_in = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state at every offset and on both outputs
        for (int a = 0; a < 9; a++) expect_reg("R11 reset read", 4'(a), 32'h0);
        check("R11 irq_norm", {31'b0, irq_norm}, 32'h0);
        check("R11 irq_crit", {31'b0, irq_crit}, 32'h0);

        // R1: plain read/write registers
        wreg(4'd2, 32'h1234_5678); expect_reg("R1 enable", 4'd2, 32'h1234_5678);
        wreg(4'd3, 32'h9ABC_DEF0); expect_reg("R1 class", 4'd3, 32'h9ABC_DEF0);
        wreg(4'd4, 32'h0F0F_00FF); expect_reg("R1 polarity", 4'd4, 32'h0F0F_00FF);
        wreg(4'd5, 32'hFFFF_0000); expect_reg("R1 trigger", 4'd5, 32'hFFFF_0000);
        wreg(4'd2, 32'h0); wreg(4'd3, 32'h0);

        // R2, R3: sticky sources, one line at a time
        wreg(4'd5, 32'hFFFF_FFFF);
        for (int n = 0; n < 32; n++) begin
            @(negedge clk); irq_in = 32'h1 << n;
            @(negedge clk); irq_in = '0;
            expect_reg("R2 line-to-bit", 4'd0, 32'h1 << (31 - n));
            repeat (2) @(negedge clk);
            expect_reg("R3 sticky hold", 4'd0, 32'h1 << (31 - n));
            wreg(4'd0, 32'hFFFF_FFFF);
            expect_reg("R5 clear sticky", 4'd0, 32'h0);
        end
        // R3: a held input sets the bit again after a clear
        @(negedge clk); irq_in = 32'h0000_0004;
        wreg(4'd0, 32'hFFFF_FFFF);
        expect_reg("R3 held re-set", 4'd0, 32'h2000_0000);
        irq_in = '0;
        wreg(4'd0, 32'hFFFF_FFFF);

        // R4, R5: level sources
        wreg(4'd5, 32'h0);
        for (int n = 0; n < 32; n++) begin
            @(negedge clk); irq_in = 32'h1 << n;
            @(negedge clk);
            expect_reg("R4 level set", 4'd0, 32'h1 << (31 - n));
            wreg(4'd0, 32'h1 << (31 - n));
            expect_reg("R5 level reassert", 4'd0, 32'h1 << (31 - n));
            irq_in = '0;
            @(negedge clk);
            expect_reg("R4 level drop", 4'd0, 32'h0);
        end

        // R5: set register, then partial clear
        wreg(4'd5, 32'hFFFF_FFFF);
        wreg(4'd1, 32'hA5A5_0F0F);
        expect_reg("R1 status at 0", 4'd0, 32'hA5A5_0F0F);
        expect_reg("R1 status at 1", 4'd1, 32'hA5A5_0F0F);
        wreg(4'd0, 32'h0000_0F00);
        expect_reg("R5 partial clear", 4'd0, 32'hA5A5_000F);

        // R7: masked status; writes to 6 and 7 have no effect
        wreg(4'd2, 32'hFF00_FF00);
        expect_reg("R7 masked", 4'd6, 32'hA500_0000);
        wreg(4'd6, 32'hFFFF_FFFF);
        wreg(4'd7, 32'hFFFF_FFFF);
        expect_reg("R7 status kept", 4'd0, 32'hA5A5_000F);
        expect_reg("R7 enable kept", 4'd2, 32'hFF00_FF00);
        expect_reg("R7 class kept", 4'd3, 32'h0);
        expect_reg("R7 vector kept", 4'd7, 32'h0);

        // R6: output sweep over status, enable and class patterns
        for (int si = 0; si < 4; si++)
            for (int ei = 0; ei < 4; ei++)
                for (int ci = 0; ci < 4; ci++) begin
                    wreg(4'd0, 32'hFFFF_FFFF);
                    wreg(4'd1, pat(si));
                    wreg(4'd2, pat(ei));
                    wreg(4'd3, pat(ci));
                    #1;
                    check("R6 irq_norm", {31'b0, irq_norm}, {31'b0, |(pat(si) & pat(ei) & ~pat(ci))});
                    check("R6 irq_crit", {31'b0, irq_crit}, {31'b0, |(pat(si) & pat(ei) & pat(ci))});
                end

        // R8: configuration bit 1 forced low
        wreg(4'd8, 32'hFFFF_FFFF); expect_reg("R8 cfg store", 4'd8, 32'hFFFF_FFFD);
        wreg(4'd8, 32'h0000_0002); expect_reg("R8 cfg bit1", 4'd8, 32'h0);

        // R10: no critical pending gives vector 0
        wreg(4'd0, 32'hFFFF_FFFF);
        wreg(4'd1, 32'h0F00_00F0);
        wreg(4'd2, 32'hFFFF_FFFF);
        wreg(4'd3, 32'h0);
        wreg(4'd8, 32'h4000_0001);
        expect_reg("R10 idle vector", 4'd7, 32'h0);

        // R9: two pending critical bits, both scan directions
        wreg(4'd3, 32'hFFFF_FFFF);
        for (int dir = 0; dir < 2; dir++)
            for (int b = 0; b < 32; b++) begin
                int b2, lo, hi;
                logic [31:0] exp_vec;
                b2 = (b + 7) % 32;
                lo = (b < b2) ? b : b2;
                hi = (b < b2) ? b2 : b;
                exp_vec = (dir == 0) ? (32'h00C4_0004 + 32'(lo) * 512)
                                     : (32'h00C4_0004 + 32'(31 - hi) * 512);
                wreg(4'd0, 32'hFFFF_FFFF);
                wreg(4'd1, (32'h1 << b) | (32'h1 << b2));
                wreg(4'd8, 32'h00C4_0006 | 32'(dir));
                expect_reg("R9 vector", 4'd7, exp_vec);
                check("R9 irq_crit", {31'b0, irq_crit}, 32'h1);
                check("R9 irq_norm", {31'b0, irq_norm}, 32'h0);
                reg_addr = 4'd7; #1;
                check("R10 novec vector", rdata_nv, 32'h0);
                reg_addr = 4'd8; #1;
                check("R10 novec cfg", rdata_nv, 32'h0);
            end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule